// File: doc/BRIEF.md
# Bundle Multiplexer Scaled Adder

This block computes a weighted mix of two values carried as parallel probabilistic bundles. A value in [0, 1] is represented by a bundle of N wires, and the value is the fraction of those wires that are 1. The block receives two such bundles, `a_bus` and `b_bus`, and a stored weight numerator K in the range 0..N. Every cycle it builds an output bundle in which exactly K wire positions are copied from `a_bus` and the remaining N−K positions are copied from `b_bus`. The output therefore represents (K/N)·a + (1−K/N)·b.

The weight is fixed by a count of wires, not by a random per-bit select stream. The randomness lies in which positions take A. That choice is a thermometer code of K ones, scrambled each cycle by a swap network driven from an LFSR. Before the merge, each input bundle also passes through its own scrambling network, so a given output position does not always read the same input wire index. The accuracy of the mix improves as N grows.

The result bundle and its popcount are registered, with one cycle of latency. All state uses a synchronous active-low reset.

Top module: `bundle_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block clears `mix_bus` to all zeros, clears `mix_count` to 0 and sets K to 0.
- R2: If `ratio_load` is 1 at an edge, K takes `ratio_in`, clamped to N when larger. If `ratio_load` is 0, K keeps its value and `ratio_in` has no effect.
- R3: Exactly K output positions carry an A wire in every cycle. With `a_bus` all ones and `b_bus` all zeros, `mix_count` equals K.
- R4: With K = 0 the output is a rearrangement of `b_bus`: `mix_count` equals the popcount of `b_bus` and `a_bus` has no effect.
- R5: With K = N the output is a rearrangement of `a_bus`: `mix_count` equals the popcount of `a_bus` and `b_bus` has no effect.
- R6: The bundles present at edge t determine `mix_bus` and `mix_count` from edge t onward, which gives one cycle of latency.
- R7: `mix_count` always equals the number of ones on `mix_bus`.
- R8: For a fixed K strictly between 0 and N, the set of positions taking A changes from cycle to cycle, and over a run every position takes A at some point.
- R9: The input wire feeding a given output position changes between cycles. With K = N and a single 1 on `a_bus`, that 1 appears on every output position over a run.
- R10: Over a long run with constant inputs, the mean of `mix_count` is within 0.35 of (K·pop(A) + (N−K)·pop(B))/N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_load | input | 1 | Writes `ratio_in` into the weight numerator K |
| ratio_in | input | $clog2(WIDTH+1) | New numerator, clamped to WIDTH |
| a_bus | input | WIDTH | Bundle A |
| b_bus | input | WIDTH | Bundle B |
| mix_bus | output | WIDTH | Registered mixed bundle |
| mix_count | output | $clog2(WIDTH+1) | Registered popcount of `mix_bus` |

## Verification
The bench builds the block with WIDTH = 8, which makes the weight register 4 bits wide. At this width every K from 0 to 8 can be swept, and every one of the 256 patterns of the passed-through bundle can be driven at K = 0 and at K = N. Loading the out-of-range codes 9 to 15 exercises the clamp. The small width also gives enough cycles to see every position take A, and to measure the mean popcount against its arithmetic expectation at two intermediate weights.

// File: rtl/bmx_pkg.sv
// Shared constants and helpers for the bundle mixer.
// Assumes a 32-bit right-shifting Galois LFSR with a maximal-length polynomial.
package bmx_pkg;
    localparam int          RNG_W    = 32;
    localparam logic [31:0] RNG_TAPS = 32'h8020_0003;

    // One step of the Galois LFSR (x^32 + x^22 + x^2 + x + 1).
    function automatic logic [RNG_W-1:0] rng_step(input logic [RNG_W-1:0] s);
        rng_step = s[0] ? ((s >> 1) ^ RNG_TAPS) : (s >> 1);
    endfunction
endpackage

// File: rtl/bmx_rng.sv
// Random control-bit source: a 32-bit LFSR advancing every cycle, widened to
// OUT_W bits by XOR-folding its state. Assumes SEED is nonzero.
module bmx_rng #(
    parameter int          OUT_W = 32,
    parameter logic [31:0] SEED  = 32'h1ACE_B00C
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] bits_o
);
    import bmx_pkg::*;

    logic [RNG_W-1:0] state_q;

    // Advance the LFSR once per cycle; reload the seed on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= rng_step(state_q);
    end

    // Map the state onto OUT_W control bits; bits past 32 fold two taps.
    for (genvar j = 0; j < OUT_W; j++) begin : g_bit
        localparam int TA = j % RNG_W;
        localparam int TB = (TA + 1 + j / RNG_W) % RNG_W;
        if (j < RNG_W) begin : g_direct
            assign bits_o[j] = state_q[TA];
        end else begin : g_fold
            assign bits_o[j] = state_q[TA] ^ state_q[TB];
        end
    end

    // R8
    state_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);
endmodule

// File: rtl/bmx_swapnet.sv
// Butterfly swap network: log2(W) stages of W/2 conditional pair swaps, each
// swap controlled by one bit. Preserves the popcount of its input.
// Assumes W is a power of two and at least 2.
module bmx_swapnet #(
    parameter int W = 16,
    localparam int LG = $clog2(W),
    localparam int CB = LG * (W / 2)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  din,
    input  logic [CB-1:0] ctrl,
    output logic [W-1:0]  dout
);
    logic [W-1:0] lvl [0:LG];

    assign lvl[0] = din;

    // Stage s swaps positions that differ only in bit s.
    for (genvar s = 0; s < LG; s++) begin : g_stage
        for (genvar p = 0; p < W / 2; p++) begin : g_pair
            localparam int LO = ((p >> s) << (s + 1)) | (p & ((1 << s) - 1));
            localparam int HI = LO + (1 << s);
            assign lvl[s+1][LO] = ctrl[s*(W/2)+p] ? lvl[s][HI] : lvl[s][LO];
            assign lvl[s+1][HI] = ctrl[s*(W/2)+p] ? lvl[s][LO] : lvl[s][HI];
        end
    end

    assign dout = lvl[LG];

    // R3
    weight_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dout) == $countones(din));
endmodule

// File: rtl/bundle_mixer.sv
// Scaled adder on probabilistic bundles. Exactly K output positions take a
// wire from A and the rest take a wire from B. Positions and source indices
// are scrambled every cycle by LFSR-driven swap networks. The output is
// registered with one cycle of latency. Assumes WIDTH is a power of two >= 2.
module bundle_mixer #(
    parameter int          WIDTH = 16,
    parameter logic [31:0] SEED  = 32'h1ACE_B00C,
    localparam int KW  = $clog2(WIDTH + 1),
    localparam int NCB = $clog2(WIDTH) * (WIDTH / 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ratio_load,
    input  logic [KW-1:0]    ratio_in,
    input  logic [WIDTH-1:0] a_bus,
    input  logic [WIDTH-1:0] b_bus,
    output logic [WIDTH-1:0] mix_bus,
    output logic [KW-1:0]    mix_count
);
    localparam logic [KW-1:0] K_MAX = KW'(WIDTH);

    logic [KW-1:0]    k_q;
    logic [WIDTH-1:0] therm;
    logic [WIDTH-1:0] sel_mask;
    logic [WIDTH-1:0] net_in  [3];
    logic [WIDTH-1:0] net_out [3];
    logic [NCB-1:0]   net_ctrl[3];
    logic [WIDTH-1:0] mix_next;
    logic [KW-1:0]    count_next;

    // Weight register: load with clamp to WIDTH, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          k_q <= '0;
        else if (ratio_load) k_q <= (ratio_in > K_MAX) ? K_MAX : ratio_in;
    end

    // Thermometer code with K low-order ones.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) therm[i] = (i < int'(k_q));
    end

    assign net_in[0] = therm;
    assign net_in[1] = a_bus;
    assign net_in[2] = b_bus;

    // One independent random source and scrambler per path: mask, A, B.
    for (genvar g = 0; g < 3; g++) begin : g_path
        localparam logic [31:0] PSEED = SEED ^ (32'h6D2B_79F5 * 32'(g));
        bmx_rng #(.OUT_W(NCB), .SEED(PSEED)) i_rng (
            .clk   (clk),
            .rst_n (rst_n),
            .bits_o(net_ctrl[g])
        );
        bmx_swapnet #(.W(WIDTH)) i_net (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (net_in[g]),
            .ctrl (net_ctrl[g]),
            .dout (net_out[g])
        );
    end

    assign sel_mask = net_out[0];
    assign mix_next = (sel_mask & net_out[1]) | (~sel_mask & net_out[2]);

    // Popcount of the next output bundle.
    always_comb begin
        count_next = '0;
        for (int i = 0; i < WIDTH; i++) count_next = count_next + KW'(mix_next[i]);
    end

    // Output register: bundle and its popcount.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_bus   <= '0;
            mix_count <= '0;
        end else begin
            mix_bus   <= mix_next;
            mix_count <= count_next;
        end
    end

    // R2
    k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        k_q <= K_MAX);
    // R2
    k_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ratio_load)) |->
        k_q == (($past(ratio_in) > K_MAX) ? K_MAX : $past(ratio_in)));
    // R2
    k_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(ratio_load)) |-> k_q == $past(k_q));
    // R3
    sel_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_mask) == int'(k_q));
    // R4
    pass_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(k_q) == '0) |->
        int'(mix_count) == $countones($past(b_bus)));
    // R5
    pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(k_q) == K_MAX) |->
        int'(mix_count) == $countones($past(a_bus)));
    // R7
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(mix_count) == $countones(mix_bus));
endmodule

// File: tb/test_bundle_mixer.sv
module test_bundle_mixer;
    localparam int N  = 8;
    localparam int KW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ratio_load = 1'b0;
    logic [KW-1:0] ratio_in = '0;
    logic [N-1:0]  a_bus = '0;
    logic [N-1:0]  b_bus = '0;
    logic [N-1:0]  mix_bus;
    logic [KW-1:0] mix_count;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    bundle_mixer #(.WIDTH(N)) i_bundle_mixer (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_load(ratio_load),
        .ratio_in  (ratio_in),
        .a_bus     (a_bus),
        .b_bus     (b_bus),
        .mix_bus   (mix_bus),
        .mix_count (mix_count)
    );

    function automatic int pop(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Load K: load strobe in one cycle, dropped in the next.
    task automatic set_k(input int k);
        @(negedge clk);
        ratio_load = 1'b1;
        ratio_in   = KW'(k);
        @(negedge clk);
        ratio_load = 1'b0;
    endtask

    // Drive bundles now and return after the edge that registers them.
    task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
        a_bus = a;
        b_bus = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [N-1:0] seen_or;
        logic [N-1:0] first_pat;
        int           changes;
        real          sum;
        real          expv;

        // R1: outputs cleared while in reset.
        a_bus = '1;
        b_bus = '1;
        repeat (3) @(negedge clk);
        check(mix_bus == '0, "R1 bus", int'(mix_bus), 0);
        check(mix_count == '0, "R1 count", int'(mix_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: K cleared, so the output follows B only (B=0, A=ones).
        drive('1, '0);
        check(mix_count == '0, "R1 k_zero", int'(mix_count), 0);

        // R3: exhaustive K sweep, A all ones, B all zeros, several cycles each.
        for (int k = 0; k <= N; k++) begin
            set_k(k);
            for (int c = 0; c < 4; c++) begin
                drive('1, '0);
                check(int'(mix_count) == k, "R3 count", int'(mix_count), k);
            end
        end

        // R2: codes above N clamp to N.
        for (int k = N + 1; k < (1 << KW); k++) begin
            set_k(k);
            drive('1, '0);
            check(int'(mix_count) == N, "R2 clamp", int'(mix_count), N);
        end

        // R2: without load, ratio_in has no effect.
        set_k(3);
        ratio_in = KW'(7);
        drive('1, '0);
        drive('1, '0);
        check(int'(mix_count) == 3, "R2 hold", int'(mix_count), 3);

        // R4 and R6: K=0, every B pattern, A noise, result one edge later.
        set_k(0);
        for (int v = 0; v < (1 << N); v++) begin
            drive(N'(v * 37 + 5), N'(v));
            check(int'(mix_count) == pop(N'(v)), "R4 pass_b", int'(mix_count), pop(N'(v)));
        end

        // R5 and R6: K=N, every A pattern, B noise.
        set_k(N);
        for (int v = 0; v < (1 << N); v++) begin
            drive(N'(v), N'(v * 91 + 3));
            check(int'(mix_count) == pop(N'(v)), "R5 pass_a", int'(mix_count), pop(N'(v)));
        end

        // R6: one-cycle latency on a single step of A.
        drive('0, '0);
        a_bus = '1;
        @(posedge clk);
        #1;
        check(mix_count == KW'(N), "R6 latency", int'(mix_count), N);
        @(negedge clk);

        // R7: count matches the bus over a mixed run.
        set_k(5);
        for (int c = 0; c < 32; c++) begin
            drive(N'(c * 29 + 1), N'(c * 53 + 7));
            check(int'(mix_count) == pop(mix_bus), "R7 count", int'(mix_count), pop(mix_bus));
        end

        // R8: positions taking A change over cycles and cover every wire.
        set_k(4);
        drive('1, '0);
        first_pat = mix_bus;
        seen_or   = '0;
        changes   = 0;
        for (int c = 0; c < 64; c++) begin
            drive('1, '0);
            seen_or |= mix_bus;
            if (mix_bus != first_pat) changes++;
        end
        check(changes > 0, "R8 vary", changes, 1);
        check(seen_or == '1, "R8 cover", int'(seen_or), (1 << N) - 1);

        // R9: a single A wire lands on every output position over a run.
        set_k(N);
        seen_or = '0;
        for (int c = 0; c < 64; c++) begin
            drive(N'(1), '0);
            seen_or |= mix_bus;
        end
        check(seen_or == '1, "R9 spread", int'(seen_or), (1 << N) - 1);

        // R10: long-run mean at two weights; pop(A)=6, pop(B)=2.
        for (int t = 0; t < 2; t++) begin
            int k = (t == 0) ? 2 : 5;
            set_k(k);
            drive(8'h3F, 8'h03);
            sum = 0.0;
            for (int c = 0; c < 4000; c++) begin
                drive(8'h3F, 8'h03);
                sum += real'(mix_count);
            end
            sum  = sum / 4000.0;
            expv = (real'(k) * 6.0 + real'(N - k) * 2.0) / real'(N);
            check((sum - expv < 0.35) && (expv - sum < 0.35), "R10 mean",
                  int'(sum * 100.0), int'(expv * 100.0));
        end

        finish_run();
    end
endmodule